// File: doc/BRIEF.md
# Quadrature Encoder Counter with Locked Configuration

This block turns the two phase signals of an incremental encoder into a signed-direction position count. Both phase inputs are resynchronised to the block clock. Every single-phase transition is decoded into one up or one down step, so a full cycle of the encoder gives four counts. An optional divider lets only every Nth decoded step reach the counter. N is a power of two from 1 to 128.

The counter stays inside a window set by a start register and a limit register. Stepping up from the limit lands on the start value, and stepping down from the start value lands on the limit. Each of these wraps raises a one-cycle flag. Software reaches the block through a small word-wide register bus.

The setup registers sit behind a lock, and the lock is set after reset. Software releases it with an unlock bit in the mode register and sets it again through the lock register. The start and limit registers also need the mode-enable bit. Writing the counter register never stores the bus data. It reloads the count from the start register.

Top module: `qdec_timer`

## Requirements
- R1: After reset the count is 0, the lock flag (register 5 bit 0) reads 1, the start register (2) reads 0x0000, the limit register (3) reads 0xFFFF, the divider field (register 0 bits 2:0) reads 0 and the quadrature enable (register 6 bit 0) reads 0.
- R2: With counting enabled, each change of exactly one phase moves the count by one. Taking the phases as {A,B}, the order 00, 01, 11, 10, 00 counts up and the reverse order counts down.
- R3: A change in which both phases flip between two synchronised samples leaves the count unchanged.
- R4: While the lock flag is 1, writes to register 0 (divider), register 6 (quadrature enable), registers 2 and 3 (start, limit) and the enable bit of register 4 (mode) are ignored.
- R5: Writing register 4 with bit 2 set while locked clears the lock flag. A write to register 4 without bit 2 leaves it locked.
- R6: Writing register 5 with bit 0 set sets the lock flag.
- R7: Registers 2 and 3 accept writes only when register 4 bit 0 (module enable) is 1 and the lock is clear.
- R8: Any write to register 1 (counter) loads the count from the start register, whatever the written data, and clears the divider's step accumulator.
- R9: Stepping up from the limit value gives the start value and pulses `ovf_pulse` for exactly one cycle.
- R10: Stepping down from the start value gives the limit value and pulses `unf_pulse` for exactly one cycle.
- R11: With divider field k, the count changes once for every 2^k decoded steps.
- R12: While register 6 bit 0 is 0, phase activity does not change the count.
- R13: Reads of unmapped offsets (7 and above) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (4) | Register word offset |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data for `bus_addr`, combinational |
| count | output | CNT_W (16) | Current count |
| ovf_pulse | output | 1 | One-cycle flag on an upward wrap |
| unf_pulse | output | 1 | One-cycle flag on a downward wrap |

## Verification
The bound checker watches the wrap results and the reload result on every cycle. After an overflow the count must equal the previous start value, and after an underflow it must equal the previous limit. A counter write must be followed by the start value, the two wrap flags must never be high together, and the divider and start settings must not move while the lock was set. Some behaviours appear only through the bench's scenarios: the x4 direction decoding and the rejection of double-phase transitions, the lock release and re-arm sequence, the gating of range writes by the enable bit, the divider ratio and its clearing on reload, and the zero reads of unmapped offsets.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   // Register word offsets
   typedef enum logic [3:0] {
      RA_CFG  = 4'd0,
      RA_CNT  = 4'd1,
      RA_INIT = 4'd2,
      RA_MODV = 4'd3,
      RA_MODE = 4'd4,
      RA_PROT = 4'd5,
      RA_QCTL = 4'd6
   } reg_addr_e;

   localparam int MODE_MEN_BIT  = 0;
   localparam int MODE_UNLK_BIT = 2;
   localparam int PROT_LOCK_BIT = 0;
   localparam int QCTL_EN_BIT   = 0;

   typedef struct packed {
      logic up;
      logic dn;
   } qstep_t;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      for (genvar g = 0; g < WIDTH; g++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], din[g]};
         end
         assign dout[g] = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
   import qdec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,      // {A,B}, synchronised
   output qstep_t     step
);

   logic [1:0] prev_q;
   logic       a_chg, b_chg, single, dir_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b00;
      else        prev_q <= ab;
   end

   // x4 decode: exactly one phase moved; a double change is dropped
   always_comb begin
      a_chg   = ab[1] ^ prev_q[1];
      b_chg   = ab[0] ^ prev_q[0];
      single  = a_chg ^ b_chg;
      dir_up  = prev_q[1] ^ ab[0];
      step.up = single & dir_up;
      step.dn = single & ~dir_up;
   end

endmodule

// File: rtl/qdec_count.sv
module qdec_count
   import qdec_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 3,
   parameter bit PSC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  qstep_t           step,
   input  logic             reload,
   input  logic [PSC_W-1:0] psc_sel,
   input  logic [CNT_W-1:0] init_val,
   input  logic [CNT_W-1:0] mod_val,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             unf
);

   localparam int ACC_W = (1 << PSC_W) - 1;

   logic any_step;
   logic fire;

   assign any_step = en & (step.up | step.dn);

   generate
      if (PSC_EN) begin : g_psc
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] acc_lim;
         assign acc_lim = (ACC_W'(1) << psc_sel) - ACC_W'(1);
         assign fire    = any_step & (acc_q == acc_lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        acc_q <= '0;
            else if (reload)   acc_q <= '0;
            else if (any_step) acc_q <= fire ? '0 : acc_q + ACC_W'(1);
         end
      end else begin : g_nopsc
         assign fire = any_step;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else begin
         ovf <= 1'b0;
         unf <= 1'b0;
         if (reload) begin
            count <= init_val;
         end else if (fire && step.up) begin
            if (count == mod_val) begin
               count <= init_val;
               ovf   <= 1'b1;
            end else begin
               count <= count + CNT_W'(1);
            end
         end else if (fire && step.dn) begin
            if (count == init_val) begin
               count <= mod_val;
               unf   <= 1'b1;
            end else begin
               count <= count - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/qdec_regs.sv
module qdec_regs
   import qdec_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4,
   parameter int PSC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  count,
   output logic [PSC_W-1:0]  psc_sel,
   output logic [CNT_W-1:0]  init_val,
   output logic [CNT_W-1:0]  mod_val,
   output logic              qen,
   output logic              locked,
   output logic              reload
);

   logic men_q;
   logic sel_cfg, sel_cnt, sel_init, sel_modv, sel_mode, sel_prot, sel_qctl;
   logic open_w, range_w;

   always_comb begin
      sel_cfg  = (bus_addr == ADDR_W'(RA_CFG));
      sel_cnt  = (bus_addr == ADDR_W'(RA_CNT));
      sel_init = (bus_addr == ADDR_W'(RA_INIT));
      sel_modv = (bus_addr == ADDR_W'(RA_MODV));
      sel_mode = (bus_addr == ADDR_W'(RA_MODE));
      sel_prot = (bus_addr == ADDR_W'(RA_PROT));
      sel_qctl = (bus_addr == ADDR_W'(RA_QCTL));
      open_w   = bus_wr & ~locked;
      range_w  = open_w & men_q;
   end

   assign reload = bus_wr & sel_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b1;
         men_q    <= 1'b0;
         psc_sel  <= '0;
         qen      <= 1'b0;
         init_val <= '0;
         mod_val  <= '1;
      end else begin
         if (open_w && sel_cfg)   psc_sel  <= bus_wdata[PSC_W-1:0];
         if (open_w && sel_qctl)  qen      <= bus_wdata[QCTL_EN_BIT];
         if (range_w && sel_init) init_val <= bus_wdata;
         if (range_w && sel_modv) mod_val  <= bus_wdata;
         if (bus_wr && sel_mode) begin
            if (locked) begin
               if (bus_wdata[MODE_UNLK_BIT]) locked <= 1'b0;
            end else begin
               men_q <= bus_wdata[MODE_MEN_BIT];
            end
         end
         if (bus_wr && sel_prot && bus_wdata[PROT_LOCK_BIT]) locked <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_cfg)  bus_rdata[PSC_W-1:0]     = psc_sel;
      if (sel_cnt)  bus_rdata                = count;
      if (sel_init) bus_rdata                = init_val;
      if (sel_modv) bus_rdata                = mod_val;
      if (sel_mode) bus_rdata[MODE_MEN_BIT]  = men_q;
      if (sel_prot) bus_rdata[PROT_LOCK_BIT] = locked;
      if (sel_qctl) bus_rdata[QCTL_EN_BIT]   = qen;
   end

endmodule

// File: rtl/qdec_timer.sv
module qdec_timer
   import qdec_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 4,
   parameter int PSC_W       = 3,
   parameter bit PSC_EN      = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phase_a,
   input  logic              phase_b,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_pulse,
   output logic              unf_pulse
);

   generate
      if (CNT_W < 8 || CNT_W > 32)      begin : g_bad_cnt  $error("CNT_W out of range");      end
      if (ADDR_W < 3 || ADDR_W > 4)     begin : g_bad_addr $error("ADDR_W out of range");     end
      if (PSC_W < 1 || PSC_W > 3)       begin : g_bad_psc  $error("PSC_W out of range");      end
      if (SYNC_STAGES < 2)              begin : g_bad_sync $error("SYNC_STAGES below two");   end
   endgenerate

   logic [1:0]       ab_sync;
   qstep_t           step;
   logic [PSC_W-1:0] psc_sel;
   logic [CNT_W-1:0] init_val, mod_val;
   logic             qen, locked, reload;

   qdec_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({phase_a, phase_b}),
      .dout (ab_sync)
   );

   qdec_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .ab   (ab_sync),
      .step (step)
   );

   qdec_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .count    (count),
      .psc_sel  (psc_sel),
      .init_val (init_val),
      .mod_val  (mod_val),
      .qen      (qen),
      .locked   (locked),
      .reload   (reload)
   );

   qdec_count #(.CNT_W(CNT_W), .PSC_W(PSC_W), .PSC_EN(PSC_EN)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (qen),
      .step    (step),
      .reload  (reload),
      .psc_sel (psc_sel),
      .init_val(init_val),
      .mod_val (mod_val),
      .count   (count),
      .ovf     (ovf_pulse),
      .unf     (unf_pulse)
   );

endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk
   import qdec_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4,
   parameter int PSC_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  count,
   input logic              ovf,
   input logic              unf,
   input logic [CNT_W-1:0]  init_val,
   input logic [CNT_W-1:0]  mod_val,
   input logic [PSC_W-1:0]  psc_sel,
   input logic              locked
);

   AST_OVF_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> count == $past(init_val)); // R9

   AST_UNF_TO_MODV: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> count == $past(mod_val)); // R10

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && unf)); // R9

   AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr && bus_addr == ADDR_W'(RA_CNT)) |-> count == $past(init_val)); // R8

   AST_LOCK_PSC: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> $stable(psc_sel)); // R4

   AST_LOCK_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> $stable(init_val)); // R4

endmodule

bind qdec_timer qdec_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .count   (count),
   .ovf     (ovf_pulse),
   .unf     (unf_pulse),
   .init_val(init_val),
   .mod_val (mod_val),
   .psc_sel (psc_sel),
   .locked  (locked)
);

// File: tb/qdec_timer_tb.sv
module qdec_timer_tb;

   localparam int CNT_W  = 16;
   localparam int ADDR_W = 4;
   localparam int NVEC   = 12;

   // {A,B} next state, expected count
   localparam logic [17:0] QVEC [NVEC] = '{
      {2'b01, 16'd1}, {2'b11, 16'd2}, {2'b10, 16'd3}, {2'b00, 16'd4},
      {2'b10, 16'd3}, {2'b11, 16'd2}, {2'b00, 16'd2}, {2'b01, 16'd3},
      {2'b00, 16'd2}, {2'b10, 16'd1}, {2'b00, 16'd2}, {2'b11, 16'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              phase_a = 1'b0, phase_b = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [CNT_W-1:0]  bus_wdata = '0;
   logic [CNT_W-1:0]  bus_rdata, count;
   logic              ovf_pulse, unf_pulse;

   int checks = 0;
   int errors = 0;
   int ovf_cnt = 0;
   int unf_cnt = 0;
   logic [CNT_W-1:0] rv;

   always #5 clk = ~clk;

   qdec_timer u_dut (
      .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .count(count),
      .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
   );

   always @(posedge clk) begin
      if (ovf_pulse) ovf_cnt <= ovf_cnt + 1;
      if (unf_pulse) unf_cnt <= unf_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [CNT_W-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic qset(input logic [1:0] ab);
      @(negedge clk);
      phase_a = ab[1]; phase_b = ab[0];
      repeat (4) @(negedge clk);
   endtask

   // one x4 step along the sequence 00,01,11,10
   task automatic qmove(input bit up);
      logic [1:0] cur, nxt;
      cur = {phase_a, phase_b};
      case (cur)
         2'b00: nxt = up ? 2'b01 : 2'b10;
         2'b01: nxt = up ? 2'b11 : 2'b00;
         2'b11: nxt = up ? 2'b10 : 2'b01;
         default: nxt = up ? 2'b00 : 2'b11;
      endcase
      qset(nxt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int o0, u0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 count", count, 0);
      rd(4'd5, rv); chk("R1 lock", rv, 1);
      rd(4'd2, rv); chk("R1 init", rv, 16'h0000);
      rd(4'd3, rv); chk("R1 modv", rv, 16'hFFFF);
      rd(4'd0, rv); chk("R1 psc", rv, 0);
      rd(4'd6, rv); chk("R1 qen", rv, 0);

      // R4: locked writes ignored
      wr(4'd6, 16'h0001); rd(4'd6, rv); chk("R4 qctl locked", rv, 0);
      wr(4'd0, 16'h0005); rd(4'd0, rv); chk("R4 cfg locked", rv, 0);
      wr(4'd4, 16'h0001); rd(4'd4, rv); chk("R4 mode locked", rv, 0);
      // R5: mode write without unlock bit keeps lock, with it releases
      rd(4'd5, rv); chk("R5 still locked", rv, 1);
      wr(4'd4, 16'h0004); rd(4'd5, rv); chk("R5 unlock", rv, 0);

      // R7: range write needs module enable
      wr(4'd2, 16'h0055); rd(4'd2, rv); chk("R7 init without enable", rv, 0);
      wr(4'd4, 16'h0001);
      wr(4'd2, 16'h0000); rd(4'd2, rv); chk("R7 init with enable", rv, 0);
      wr(4'd3, 16'h1234); rd(4'd3, rv); chk("R7 modv with enable", rv, 16'h1234);
      wr(4'd3, 16'hFFFF);

      // R12: no counting while quadrature disabled
      qset(2'b01); chk("R12 disabled", count, 0);
      qset(2'b00); chk("R12 disabled back", count, 0);

      wr(4'd6, 16'h0001);
      // R2/R3: vector table walk
      for (int i = 0; i < NVEC; i++) begin
         qset(QVEC[i][17:16]);
         chk((QVEC[i][17:16] == 2'b00 && i == 6) || i == 11 ? "R3 double change" : "R2 x4 step",
             count, QVEC[i][15:0]);
      end

      // R8: reload from start register, data ignored
      wr(4'd2, 16'h0010); wr(4'd3, 16'h0013);
      wr(4'd1, 16'hABCD); chk("R8 reload", count, 16'h0010);

      // R9: upward wrap
      qmove(1); qmove(1); qmove(1); chk("R9 at limit", count, 16'h0013);
      o0 = ovf_cnt;
      qmove(1); chk("R9 wrap value", count, 16'h0010);
      chk("R9 one pulse", ovf_cnt - o0, 1);
      // R10: downward wrap
      u0 = unf_cnt;
      qmove(0); chk("R10 wrap value", count, 16'h0013);
      chk("R10 one pulse", unf_cnt - u0, 1);

      // R11: divide by 4
      wr(4'd0, 16'h0002); wr(4'd1, 16'h0000);
      qmove(1); qmove(1); qmove(1); chk("R11 held", count, 16'h0010);
      qmove(1); chk("R11 fourth step", count, 16'h0011);
      // R8: reload clears accumulator
      qmove(1); qmove(1); wr(4'd1, 16'h0000);
      qmove(1); qmove(1); qmove(1); chk("R8 acc cleared", count, 16'h0010);
      qmove(1); chk("R8 acc fourth", count, 16'h0011);

      // R6: re-arm lock
      wr(4'd5, 16'h0001); rd(4'd5, rv); chk("R6 relock", rv, 1);
      wr(4'd0, 16'h0000); rd(4'd0, rv); chk("R4 cfg after relock", rv, 2);

      // R13: unmapped offsets
      rd(4'd15, rv); chk("R13 read zero", rv, 0);
      wr(4'd7, 16'hFFFF); wr(4'd15, 16'hFFFF);
      rd(4'd2, rv); chk("R13 init unchanged", rv, 16'h0010);
      rd(4'd3, rv); chk("R13 modv unchanged", rv, 16'h0013);
      chk("R13 count unchanged", count, 16'h0011);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule